// File: doc/BRIEF.md
# Peripheral Write-Lock Controller

This block holds the write-protection flags for a large set of peripherals in a chip. It sits on a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. Each implemented flag drives one output line to one peripheral. A peripheral whose line is high rejects register writes and still serves reads. A line that is low leaves that peripheral writable.

The flags can change only after software opens a key gate. Software opens the gate by writing two specific bytes in order to a key register. The gate then accepts flag updates until the next write of any kind to the key register, which closes it again. While the gate is open, each flag bank takes updates through three addresses: one replaces the whole word, one sets the bits written as 1, and one clears the bits written as 1. Each bank implements only some of its bit positions. The positions that are not implemented always read as 0 and cannot be set.

Top module: `reg_write_guard`

## Requirements
- R1: When reset is asserted, the key gate returns to the closed code 0 and every lock output drops to 0 by the next clock edge.
- R2: A read of offset 0x00 returns the gate state in bits 7:0 and zeros above. The codes are 0 for closed, 1 for first byte accepted and 2 for open.
- R3: In state 0, a key write whose low byte is 0xA5 moves the gate to state 1. A key write with any other low byte leaves the gate in state 0.
- R4: In state 1, a key write whose low byte is 0xF1 moves the gate to state 2. A key write with any other low byte moves the gate back to state 0.
- R5: In state 2, any key write moves the gate to state 0, whatever its data.
- R6: In state 2, a write to a bank's base offset (0x20 for bank 0, 0x40 for bank 1) replaces all implemented bits of that bank with the write data.
- R7: In state 2, a write to base+4 sets every implemented bit written as 1 and leaves the bits written as 0 unchanged.
- R8: In state 2, a write to base+8 clears every bit written as 1 and leaves the bits written as 0 unchanged.
- R9: In states 0 and 1, writes to any bank offset leave all lock outputs unchanged.
- R10: Bank 0 implements bits 0–22 and 27–30, and bank 1 implements only bit 0. All other bits read as 0, show 0 on the lock outputs, and ignore writes.
- R11: A read of base, base+4 or base+8 returns that bank's current flags. A read of any offset not listed here returns 0.
- R12: Lock output bits [31:0] follow bank 0 and bits [63:32] follow bank 1. A 1 means the peripheral is write-protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, sampled at the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| lockOut | output | 64 | Per-peripheral write-protect lines, bank 0 in the low word |

## Verification
The bench covers the key-sequence corner cases. A wrong first byte must leave the gate closed. A wrong second byte, including a repeated 0xA5, must drop it back to 0. Writing the correct second byte while the gate is already open must close it. A gate that skipped any of these would show a wrong code on the key readback. Bank writes are issued in each closed state and after re-locking; a design that ignored the gate would change lockOut. All-ones writes to the replace and set addresses catch reserved bits that wrongly stick. An empty set write and a partial clear catch alias logic that ends up replacing the word. A reset with flags active and the gate open must clear both the flags and the gate state.

// File: rtl/wguard_pkg.sv
package wguard_pkg;
  localparam int NBANK  = 2;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } keyState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic [NBANK-1:0] wrDirect;
    logic [NBANK-1:0] wrSet;
    logic [NBANK-1:0] wrClr;
    logic             rdKey;
    logic [NBANK-1:0] rdBank;
  } lockStrobe_t;
endpackage

// File: rtl/wguard_ctrl.sv
module wguard_ctrl
  import wguard_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  KEY_FIRST   = 8'hA5,
  parameter logic [7:0]  KEY_SECOND  = 8'hF1,
  parameter int          BANK_BASE   = 32'h20,
  parameter int          BANK_STRIDE = 32'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        keyByte,
  output keyState_t         keyState,
  output lockStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] KEY_OFS = '0;

  keyState_t        keyNext;
  logic             keyHit;
  logic             gateOpen;
  logic [NBANK-1:0] hitDirect;
  logic [NBANK-1:0] hitSet;
  logic [NBANK-1:0] hitClr;

  assign keyHit   = (busAddr == KEY_OFS);
  assign gateOpen = (keyState == KS_OPEN);

  for (genvar i = 0; i < NBANK; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BANK_BASE + i * BANK_STRIDE);
    assign hitDirect[i] = (busAddr == BASE);
    assign hitSet[i]    = (busAddr == BASE + ADDR_W'(4));
    assign hitClr[i]    = (busAddr == BASE + ADDR_W'(8));
  end

  always_comb begin
    keyNext = keyState;
    if (busWrEn && keyHit) begin
      unique case (keyState)
        KS_LOCKED: if (keyByte == KEY_FIRST) keyNext = KS_HALF;
        KS_HALF:   keyNext = (keyByte == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
        default:   keyNext = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KS_LOCKED;
    else       keyState <= keyNext;
  end

  always_comb begin
    strobe.wrDirect = (busWrEn && gateOpen) ? hitDirect : '0;
    strobe.wrSet    = (busWrEn && gateOpen) ? hitSet    : '0;
    strobe.wrClr    = (busWrEn && gateOpen) ? hitClr    : '0;
    strobe.rdKey    = keyHit;
    strobe.rdBank   = hitDirect | hitSet | hitClr;
  end
endmodule

// File: rtl/wguard_dp.sv
module wguard_dp
  import wguard_pkg::*;
#(
  parameter logic [NBANK-1:0][WORD_W-1:0] IMPL_MASK = {32'h0000_0001, 32'h787F_FFFF}
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lockStrobe_t             strobe,
  input  logic [WORD_W-1:0]       wrData,
  input  keyState_t               keyState,
  output logic [WORD_W-1:0]       rdData,
  output logic [NBANK*WORD_W-1:0] lockFlat
);
  logic [NBANK-1:0][WORD_W-1:0] bankRd;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic [WORD_W-1:0] MASK = IMPL_MASK[i];
    logic [WORD_W-1:0] bankQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   bankQ <= '0;
      else if (strobe.wrDirect[i]) bankQ <= wrData & MASK;
      else if (strobe.wrSet[i])    bankQ <= bankQ | (wrData & MASK);
      else if (strobe.wrClr[i])    bankQ <= bankQ & ~wrData;
    end

    assign lockFlat[i*WORD_W +: WORD_W] = bankQ;
    assign bankRd[i] = strobe.rdBank[i] ? bankQ : '0;
  end

  always_comb begin
    rdData = strobe.rdKey ? WORD_W'(keyState) : '0;
    for (int i = 0; i < NBANK; i++) rdData = rdData | bankRd[i];
  end
endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard
  import wguard_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  KEY_FIRST   = 8'hA5,
  parameter logic [7:0]  KEY_SECOND  = 8'hF1,
  parameter int          BANK_BASE   = 32'h20,
  parameter int          BANK_STRIDE = 32'h20,
  parameter logic [NBANK-1:0][WORD_W-1:0] IMPL_MASK = {32'h0000_0001, 32'h787F_FFFF}
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [WORD_W-1:0]       busWrData,
  output logic [WORD_W-1:0]       busRdData,
  output logic [NBANK*WORD_W-1:0] lockOut
);
  keyState_t   keyState;
  lockStrobe_t strobe;

  wguard_ctrl #(
    .ADDR_W(ADDR_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
    .BANK_BASE(BANK_BASE), .BANK_STRIDE(BANK_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .keyByte(busWrData[7:0]), .keyState(keyState), .strobe(strobe)
  );

  wguard_dp #(.IMPL_MASK(IMPL_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .keyState(keyState), .rdData(busRdData), .lockFlat(lockOut)
  );
endmodule

// File: rtl/wguard_chk.sv
module wguard_chk
  import wguard_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] KEY_FIRST  = 8'hA5,
  parameter logic [7:0] KEY_SECOND = 8'hF1,
  parameter logic [NBANK*WORD_W-1:0] IMPL_FLAT = 64'h0000_0001_787F_FFFF
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       busAddr,
  input logic                    busWrEn,
  input logic [WORD_W-1:0]       busWrData,
  input logic [WORD_W-1:0]       busRdData,
  input logic [NBANK*WORD_W-1:0] lockOut,
  input keyState_t               keyState
);
  logic keyWr;
  assign keyWr = busWrEn && (busAddr == '0);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (lockOut == '0));

  assert_key_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == '0) |-> (busRdData[WORD_W-1:8] == '0));

  assert_first_key_R3: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && keyState == KS_LOCKED && busWrData[7:0] == KEY_FIRST) |=> (keyState == KS_HALF));

  assert_second_ok_R4: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && keyState == KS_HALF && busWrData[7:0] == KEY_SECOND) |=> (keyState == KS_OPEN));

  assert_second_bad_R4: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && keyState == KS_HALF && busWrData[7:0] != KEY_SECOND) |=> (keyState == KS_LOCKED));

  assert_relock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && keyState == KS_OPEN) |=> (keyState == KS_LOCKED));

  assert_closed_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (keyState != KS_OPEN) |=> $stable(lockOut));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((lockOut & ~IMPL_FLAT) == '0));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(8'h10)) |-> (busRdData == '0));
endmodule

bind reg_write_guard wguard_chk #(
  .ADDR_W(ADDR_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND), .IMPL_FLAT(IMPL_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .lockOut(lockOut), .keyState(keyState)
);

// File: tb/sim_reg_write_guard.sv
module sim_reg_write_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  typedef struct packed {
    logic        wr;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] er;
    logic [63:0] el;
    logic [7:0]  rq;
  } vec_t;

  // write, write addr, write data, read addr, expected read, expected locks, requirement
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h0000_005A, 8'h00, 32'h0,          64'h0,                     8'd3},  // R3 wrong first byte
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 8'h20, 32'h0,          64'h0,                     8'd9},  // R9 closed
    '{1'b1, 8'h00, 32'h0000_00A5, 8'h00, 32'h1,          64'h0,                     8'd3},  // R3
    '{1'b1, 8'h00, 32'h0000_0000, 8'h00, 32'h0,          64'h0,                     8'd4},  // R4 bad second
    '{1'b1, 8'h00, 32'h0000_00A5, 8'h00, 32'h1,          64'h0,                     8'd3},  // R3
    '{1'b1, 8'h00, 32'h0000_00F1, 8'h00, 32'h2,          64'h0,                     8'd4},  // R4 open, R2
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 8'h20, 32'h787F_FFFF,  64'h0000_0000_787F_FFFF,   8'd6},  // R6 R10
    '{1'b1, 8'h28, 32'h0000_000F, 8'h24, 32'h787F_FFF0,  64'h0000_0000_787F_FFF0,   8'd8},  // R8 R11
    '{1'b1, 8'h40, 32'hFFFF_FFFF, 8'h48, 32'h0000_0001,  64'h0000_0001_787F_FFF0,   8'd10}, // R10 R12
    '{1'b1, 8'h44, 32'h0000_0000, 8'h40, 32'h0000_0001,  64'h0000_0001_787F_FFF0,   8'd7},  // R7 zeros
    '{1'b1, 8'h48, 32'h0000_0001, 8'h40, 32'h0000_0000,  64'h0000_0000_787F_FFF0,   8'd8},  // R8
    '{1'b1, 8'h24, 32'h8000_0005, 8'h20, 32'h787F_FFF5,  64'h0000_0000_787F_FFF5,   8'd7},  // R7 R10
    '{1'b1, 8'h20, 32'h0000_0003, 8'h20, 32'h0000_0003,  64'h0000_0000_0000_0003,   8'd6},  // R6
    '{1'b1, 8'h00, 32'h0000_00F1, 8'h00, 32'h0,          64'h0000_0000_0000_0003,   8'd5},  // R5
    '{1'b1, 8'h24, 32'hFFFF_FFFF, 8'h20, 32'h0000_0003,  64'h0000_0000_0000_0003,   8'd9},  // R9 after relock
    '{1'b0, 8'h00, 32'h0,         8'h10, 32'h0,          64'h0000_0000_0000_0003,   8'd11}, // R11 unmapped
    '{1'b0, 8'h00, 32'h0,         8'h4C, 32'h0,          64'h0000_0000_0000_0003,   8'd11}, // R11 unmapped
    '{1'b1, 8'h00, 32'h0000_00A5, 8'h00, 32'h1,          64'h0000_0000_0000_0003,   8'd3},  // R3
    '{1'b1, 8'h00, 32'h0000_00A5, 8'h00, 32'h0,          64'h0000_0000_0000_0003,   8'd4}   // R4 repeat first
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] lockOut;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_write_guard u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .lockOut(lockOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic readAt(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; #1;
    d = busRdData;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state
    readAt(8'h00, rd);
    chk("R1 key after reset", 64'(rd), 64'h0);
    chk("R1 locks after reset", lockOut, 64'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busWrEn = VEC[i].wr; busAddr = VEC[i].wa; busWrData = VEC[i].wd;
      @(posedge clk); #1;
      busWrEn = 1'b0;
      readAt(VEC[i].ra, rd);
      chk($sformatf("R%0d vec%0d read", VEC[i].rq, i), 64'(rd), 64'(VEC[i].er));
      chk($sformatf("R12 vec%0d locks", i), lockOut, VEC[i].el);
    end

    // R1: reset while open with flags set
    busWrite(8'h00, 32'hA5);
    busWrite(8'h00, 32'hF1);
    busWrite(8'h40, 32'h1);
    chk("R6 bank1 set before reset", lockOut, 64'h0000_0001_0000_0003);
    @(negedge clk) rstN = 1'b0;
    @(posedge clk); #1;
    chk("R1 locks cleared by reset", lockOut, 64'h0);
    readAt(8'h00, rd);
    chk("R1 key closed by reset", 64'(rd), 64'h0);
    @(negedge clk) rstN = 1'b1;

    // R3: second byte first does not open
    busWrite(8'h00, 32'hF1);
    readAt(8'h00, rd);
    chk("R3 second byte in state 0", 64'(rd), 64'h0);
    // R3: only low byte matters
    busWrite(8'h00, 32'hFFFF_FFA5);
    readAt(8'h00, rd);
    chk("R3 low byte key", 64'(rd), 64'h1);
    chk("R2 upper bits zero", 64'(rd[31:8]), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule